// File: doc/BRIEF.md
# Software-Triggered Peripheral Reset Sequencer

This block lets software pulse the reset input of a chosen set of peripheral domains. It sits on a simple register bus and has two windows. Window 0 holds a domain-select mask. Window 1 holds a trigger register. The trigger register carries a self-clearing start bit and a pulse-length field.

Software first writes the mask. It then writes the trigger with the start bit set. The sequencer records the mask as it stands at that write. It then holds reset high on every recorded domain for a programmed number of cycles and releases all of them together. When the pulse ends, the start bit reads back as zero. Software polls that bit to learn that the reset has finished.

A bus access takes effect in a cycle where `busSel` and `busEnable` are both high. `busWrite` tells a write from a read. `busWin` picks the window. Only byte offset 0 of each window is backed by a register. Read data is combinational from the current address.

Top module: `pulse_rst_ctrl`

## Requirements
- R1: The select register sits at window 0 (`busWin`=0), offset 0. It stores only the nine domain bits 16 to 22, 25 and 31. Every other bit reads as zero, whatever was written.
- R2: A write to the trigger register (`busWin`=1, offset 0) with bit 0 set, made while idle, starts a pulse. The pulse covers the domains selected by the mask held at that write. Output `domRst[0]` to `domRst[6]` follow mask bits 16 to 22, `domRst[7]` follows bit 25 and `domRst[8]` follows bit 31.
- R3: `domRst` is registered and active-high. It rises at the clock edge that takes the trigger write. It stays high for exactly 4 + D cycles, where D is the value written to trigger bits 31:16. D = 0 gives 4 cycles.
- R4: Trigger bit 0 reads 1 for the whole pulse. It reads 0 from the edge at which `domRst` falls.
- R5: Trigger bits 31:16 read back the last delay value accepted. Trigger bits 15:1 always read zero.
- R6: A trigger write made during a pulse is ignored. It neither restarts nor lengthens the pulse, and the stored delay field is left unchanged.
- R7: A mask write made during a pulse changes the select register but does not change which domains are being pulsed.
- R8: Unselected domains are never asserted. All selected domains assert on the same edge and deassert on the same edge.
- R9: Global reset (`rstN` low) clears both registers, drives every `domRst` low and leaves the sequencer idle, even in the middle of a pulse.
- R10: Reads from any nonzero offset return zero. Writes to any nonzero offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous global reset, active low |
| busSel | input | 1 | Access select |
| busEnable | input | 1 | Access phase; the access happens when high together with busSel |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWin | input | 1 | Window: 0 = select mask, 1 = trigger |
| busAddr | input | 4 | Byte offset within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| domRst | output | 9 | Per-domain reset, active high |

## Verification
The main function is driven with random masks that also set reserved bits, paired with random small delays. These runs separate correct domain mapping and mask capture from masks that leak reserved bits or pulse the wrong domains. Directed cases then check pulse length at the extremes: delay 0 gives the minimum of 4 cycles and the full 16-bit delay gives the maximum. A trigger written mid-pulse and a mask written mid-pulse check that a pulse in progress cannot be restarted or retargeted. A reset asserted mid-pulse and writes to nonzero offsets check that the sequencer returns to idle and that unbacked addresses are inert.

// File: rtl/prc_pkg.sv
package prc_pkg;

  // Strobes from control to datapath, one per datapath action
  typedef struct packed {
    logic loadMask;
    logic loadDelay;
    logic start;
    logic tick;
    logic finish;
  } prcStrobe_t;

  // Number of set bits in a mask
  function automatic int countBits(logic [31:0] m);
    int total;
    total = 0;
    for (int b = 0; b < 32; b++) begin
      if (m[b]) total = total + 1;
    end
    return total;
  endfunction

  // Bit position of the n-th set bit (n counted from 0)
  function automatic int nthBit(logic [31:0] m, int n);
    int seen;
    int pos;
    seen = 0;
    pos = 0;
    for (int b = 0; b < 32; b++) begin
      if (m[b]) begin
        if (seen == n) pos = b;
        seen = seen + 1;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/prc_ctrl.sv
module prc_ctrl
  import prc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busEnable,
  input  logic       busWrite,
  input  logic       busWin,
  input  logic       addrZero,
  input  logic       startBit,
  input  logic       cntZero,
  output prcStrobe_t strobe,
  output logic       busy
);

  typedef enum logic {ST_IDLE, ST_PULSE} state_t;
  state_t state, stateNext;

  logic wrAccess;
  logic wrSelReg;
  logic wrTrigReg;

  assign wrAccess  = busSel && busEnable && busWrite && addrZero;
  assign wrSelReg  = wrAccess && !busWin;
  assign wrTrigReg = wrAccess && busWin;

  always_comb begin
    strobe           = '0;
    stateNext        = state;
    strobe.loadMask  = wrSelReg;
    unique case (state)
      ST_IDLE: begin
        strobe.loadDelay = wrTrigReg;
        strobe.start     = wrTrigReg && startBit;
        if (wrTrigReg && startBit) stateNext = ST_PULSE;
      end
      ST_PULSE: begin
        strobe.tick   = !cntZero;
        strobe.finish = cntZero;
        if (cntZero) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_PULSE);

endmodule

// File: rtl/prc_datapath.sv
module prc_datapath
  import prc_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 4,
  parameter logic [31:0] DOM_MASK  = 32'h827F_0000,
  parameter int          DELAY_LSB = 16,
  parameter int          MIN_LEN   = 4,
  parameter int          NUM_DOM   = 9,
  parameter int          CNT_W     = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  prcStrobe_t        strobe,
  input  logic              busy,
  input  logic              busSel,
  input  logic              busWin,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              cntZero,
  output logic [DATA_W-1:0] selMask,
  output logic [CNT_W-1:0]  cnt,
  output logic [NUM_DOM-1:0] domRst
);

  localparam int DELAY_W = DATA_W - DELAY_LSB;

  logic [DELAY_W-1:0] delayReg;
  logic [DELAY_W-1:0] wrDelay;
  logic [NUM_DOM-1:0] gathered;

  assign wrDelay = busWdata[DATA_W-1:DELAY_LSB];

  // Pick the valid mask bits out into domain order
  for (genvar i = 0; i < NUM_DOM; i++) begin : g_gather
    assign gathered[i] = selMask[nthBit(DOM_MASK, i)];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selMask  <= '0;
      delayReg <= '0;
      cnt      <= '0;
      domRst   <= '0;
    end else begin
      if (strobe.loadMask)  selMask  <= busWdata & DOM_MASK[DATA_W-1:0];
      if (strobe.loadDelay) delayReg <= wrDelay;
      if (strobe.start) begin
        cnt    <= CNT_W'(MIN_LEN - 1) + CNT_W'(wrDelay);
        domRst <= gathered;
      end else if (strobe.tick) begin
        cnt <= cnt - 1'b1;
      end else if (strobe.finish) begin
        domRst <= '0;
      end
    end
  end

  assign cntZero = (cnt == '0);

  always_comb begin
    busRdata = '0;
    if (busSel && (busAddr == '0)) begin
      if (busWin) busRdata = {delayReg, {(DELAY_LSB-1){1'b0}}, busy};
      else        busRdata = selMask;
    end
  end

endmodule

// File: rtl/pulse_rst_ctrl.sv
module pulse_rst_ctrl
  import prc_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 4,
  parameter logic [31:0] DOM_MASK  = 32'h827F_0000,
  parameter int          DELAY_LSB = 16,
  parameter int          MIN_LEN   = 4,
  localparam int         NUM_DOM   = countBits(DOM_MASK),
  localparam int         CNT_W     = DATA_W - DELAY_LSB + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busEnable,
  input  logic               busWrite,
  input  logic               busWin,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_DOM-1:0] domRst
);

  prcStrobe_t         strobe;
  logic               busy;
  logic               cntZero;
  logic [DATA_W-1:0]  selMask;
  logic [CNT_W-1:0]   cnt;

  prc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busEnable (busEnable),
    .busWrite  (busWrite),
    .busWin    (busWin),
    .addrZero  (busAddr == '0),
    .startBit  (busWdata[0]),
    .cntZero   (cntZero),
    .strobe    (strobe),
    .busy      (busy)
  );

  prc_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .DOM_MASK  (DOM_MASK),
    .DELAY_LSB (DELAY_LSB),
    .MIN_LEN   (MIN_LEN),
    .NUM_DOM   (NUM_DOM),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busy     (busy),
    .busSel   (busSel),
    .busWin   (busWin),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .cntZero  (cntZero),
    .selMask  (selMask),
    .cnt      (cnt),
    .domRst   (domRst)
  );

endmodule

// File: rtl/prc_checker.sv
module prc_checker
  import prc_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] DOM_MASK = 32'h827F_0000,
  parameter int          NUM_DOM  = 9,
  parameter int          CNT_W    = 17
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic [CNT_W-1:0]   cnt,
  input logic [DATA_W-1:0]  selMask,
  input logic [NUM_DOM-1:0] domRst,
  input logic               busSel,
  input logic               busWin,
  input logic [DATA_W-1:0]  busRdata
);

  logic [NUM_DOM-1:0] maskDom;
  for (genvar i = 0; i < NUM_DOM; i++) begin : g_map
    assign maskDom[i] = selMask[nthBit(DOM_MASK, i)];
  end

  // R4: any asserted domain implies the sequencer reports busy
  a_r4_busy_covers_rst: assert property (@(posedge clk) disable iff (!rstN)
    (|domRst) |-> busy);

  // R3, R6: while pulsing, the counter only steps down by one
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rstN)
    busy && (cnt != '0) |=> busy && (cnt == $past(cnt) - 1'b1));

  // R3: the pulse ends only once the count is exhausted
  a_r3_finish_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(cnt) == '0));

  // R2, R8: the pulsed set equals the mask held at the trigger write
  a_r2_capture: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (domRst == $past(maskDom)));

  // R7, R8: once asserted, the domain set never changes until release
  a_r8_outputs_stable: assert property (@(posedge clk) disable iff (!rstN)
    (|domRst) && $past(|domRst) |-> (domRst == $past(domRst)));

  // R1: reserved select bits never read as one
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWin |-> ((busRdata & ~DOM_MASK[DATA_W-1:0]) == '0));

endmodule

bind pulse_rst_ctrl prc_checker #(
  .DATA_W   (DATA_W),
  .DOM_MASK (DOM_MASK),
  .NUM_DOM  (NUM_DOM),
  .CNT_W    (CNT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .cnt      (cnt),
  .selMask  (selMask),
  .domRst   (domRst),
  .busSel   (busSel),
  .busWin   (busWin),
  .busRdata (busRdata)
);

// File: tb/sim_pulse_rst_ctrl.sv
module sim_pulse_rst_ctrl;

  localparam logic [31:0] VALID = 32'h827F_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busEnable = 1'b0;
  logic        busWrite = 1'b0;
  logic        busWin = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [8:0]  domRst;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  pulse_rst_ctrl u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
    .busWrite(busWrite), .busWin(busWin), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .domRst(domRst)
  );

  always #10 clk = ~clk;

  function automatic logic [8:0] toDom(logic [31:0] m);
    logic [8:0] d;
    for (int i = 0; i < 7; i++) d[i] = m[16+i];
    d[7] = m[25];
    d[8] = m[31];
    return d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic w, input logic [3:0] a, input logic [31:0] d);
    busSel = 1; busEnable = 1; busWrite = 1; busWin = w; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busEnable = 0; busWrite = 0;
  endtask

  task automatic rd(input logic w, input logic [3:0] a, output logic [31:0] d);
    busSel = 1; busEnable = 1; busWrite = 0; busWin = w; busAddr = a;
    #1 d = busRdata;
    busSel = 0; busEnable = 0;
  endtask

  // mode 0: plain, 1: retrigger mid-pulse, 2: mask rewrite mid-pulse
  task automatic runPulse(input logic [31:0] mask, input logic [15:0] dly, input int mode);
    logic [8:0]  expDom;
    logic [31:0] r;
    logic [31:0] newMask;
    int n;
    newMask = 32'h0000_0000 | ((~mask) & VALID);
    expDom = toDom(mask);
    wr(0, 0, mask);
    wr(1, 0, {dly, 15'b0, 1'b1});
    n = 0;
    while (domRst === expDom && n < 70000) begin
      n++;
      if (n == 2) begin
        rd(1, 0, r);
        check("R4 busy during pulse", {31'b0, r[0]}, 32'd1);
      end
      if (mode == 1 && n == 3)      wr(1, 0, {16'h0005, 15'b0, 1'b1});
      else if (mode == 2 && n == 3) wr(0, 0, newMask);
      else @(negedge clk);
    end
    check("R8 all domains released together", {23'b0, domRst}, 32'd0);
    check(mode == 1 ? "R6 length unchanged by retrigger" : "R3 pulse length",
          n, 4 + dly);
    rd(1, 0, r);
    check("R4 start bit cleared", {31'b0, r[0]}, 32'd0);
    check(mode == 1 ? "R6 delay not overwritten" : "R5 delay readback",
          {16'b0, r[31:16]}, {16'b0, dly});
    check("R5 reserved trigger bits", {17'b0, r[15:1]}, 32'd0);
    if (mode == 2) begin
      rd(0, 0, r);
      check("R7 mask rewritten mid-pulse", r, newMask);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] m;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R9 reset state
    check("R9 domRst after reset", {23'b0, domRst}, 32'd0);
    rd(0, 0, r); check("R9 select cleared", r, 32'd0);
    rd(1, 0, r); check("R9 trigger cleared", r, 32'd0);

    // R1 reserved bits dropped
    wr(0, 0, 32'hFFFF_FFFF);
    rd(0, 0, r); check("R1 select valid bits", r, VALID);

    // R2 single-domain mapping, R3 minimum length
    runPulse(32'h0001_0000, 16'd0, 0);
    runPulse(32'h8000_0000, 16'd1, 0);
    runPulse(32'h0200_0000, 16'd3, 0);

    // R2, R3, R8 random masks including reserved bits
    for (int k = 0; k < 12; k++) begin
      m = $urandom();
      if ((m & VALID) == 0) m = m | 32'h0040_0000;
      runPulse(m, 16'($urandom() % 40), 0);
    end

    // R6 retrigger ignored, R7 mask change ignored by live pulse
    runPulse(32'h827F_0000, 16'd20, 1);
    runPulse(32'h0005_0000, 16'd20, 2);

    // R10 nonzero offsets
    wr(0, 0, 32'h0001_0000);
    wr(0, 4'h4, 32'h8000_0000);
    rd(0, 0, r);    check("R10 write to offset 4 ignored", r, 32'h0001_0000);
    rd(0, 4'h4, r); check("R10 offset 4 reads zero", r, 32'd0);
    wr(1, 4'h8, 32'h0003_0001);
    @(negedge clk);
    check("R10 trigger at offset 8 ignored", {23'b0, domRst}, 32'd0);
    rd(1, 4'h8, r); check("R10 offset 8 reads zero", r, 32'd0);

    // R3 maximum delay
    runPulse(32'h0010_0000, 16'hFFFF, 0);

    // R9 reset during a pulse
    wr(0, 0, 32'h0003_0000);
    wr(1, 0, {16'd50, 15'b0, 1'b1});
    repeat (5) @(negedge clk);
    check("R2 pulse running before reset", {23'b0, domRst}, 32'h3);
    rstN = 0;
    #1;
    check("R9 outputs drop on reset", {23'b0, domRst}, 32'd0);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R9 outputs low after reset", {23'b0, domRst}, 32'd0);
    rd(1, 0, r); check("R9 sequencer idle after reset", r, 32'd0);
    rd(0, 0, r); check("R9 mask cleared after reset", r, 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule